// File: doc/BRIEF.md
# BCD Calendar Timekeeper Register File

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of week, date, month and a two-digit year, each as a packed BCD field. A built-in prescaler divides an oscillator-rate tick down to one advance per second. The date wraps at the end of each month, with February taking a 29th day when the year is a multiple of four.

The host reaches the block through a plain byte-wide register port: an address, write data, a write strobe and combinational read data. A serial slave would normally sit in front of this port. Multi-byte time accesses are made coherent by two modes in the control register. Read mode freezes a snapshot of all seven time fields, while the live counters keep running underneath it. Write mode routes time writes into a holding copy, and the live counters take that copy in one step when write mode is released.

Sticky status flags report a low battery, a reset since the last clear, and a year rollover. A calibration register carries an active-low oscillator enable. That bit comes out of reset set, so the clock stays stopped until software clears it.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: After reset the control register reads 0x10 (reset flag set) and the calibration register reads 0x80 (oscillator disabled). The time reads 00:00:00, day of week 01, date 01, month 01, year 00.
- R2: The address map is 0x0 control, 0x1 calibration, 0x2 seconds, 0x3 minutes, 0x4 hours, 0x5 day of week, 0x6 date, 0x7 month, 0x8 year. Addresses 0x9 to 0xF read 0x00.
- R3: While calibration bit 7 is 1 the time does not advance. While it is 0, seconds advance once per TICKS_PER_SEC pulses of tick_i.
- R4: The fields carry in BCD. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, day of week wraps 7 to 1, and month wraps 12 to 01 with a year increment.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other long months. In month 02 it wraps after 29 when the binary year value is divisible by 4, and after 28 otherwise.
- R6: A year step from 99 to 00 sets control bit 5. Writing 0 to that bit clears it.
- R7: Writing control bit 0 from 0 to 1 captures all seven time fields. While bit 0 stays 1, reads of 0x2 to 0x8 return the captured values as ticks advance the live time. With bit 0 clear, reads return the live time.
- R8: Writing control bit 1 from 0 to 1 copies the live time into a holding copy. While bit 1 is 1, writes to 0x2 to 0x8 update only that copy, and reads of those addresses return it. Writing bit 1 from 1 to 0 loads the copy into the live time and clears the prescaler.
- R9: With control bit 1 clear, writes to 0x2 to 0x8 are ignored.
- R10: Control bit 7 (low battery) is set while batt_low_i is 1 and stays set afterwards. Control bit 4 (reset flag) is set only by reset. Writing 0 to either bit clears it, and writing 1 leaves it unchanged.
- R11: Time fields store only their width: seconds and minutes 7 bits, hours and date 6 bits, day of week 3 bits, month 5 bits, year 8 bits. Unused upper bits read 0.
- R12: When the write-mode release falls in the same cycle as a second advance, the held values are loaded without the advance. The next advance follows a full TICKS_PER_SEC ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oscillator-rate tick, one cycle per pulse |
| batt_low_i | input | 1 | Low-battery indication from the supply monitor |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
A host write that releases write mode can land on the same clock edge as the prescaler's terminal tick. In that case the block has to choose between the loaded time and the incremented time. The bench forces this collision: it runs the prescaler to one count short of terminal, then drives the release write and a tick pulse in the same cycle. It then expects the held seconds unchanged, no advance after three further ticks, and an advance on the fourth.

A read-mode capture can also share an edge with a second advance. The captured value is judged against the time held before that edge, while the live counters move on underneath.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_CAL  = 4'h1;
  localparam logic [3:0] ADDR_SEC  = 4'h2;
  localparam logic [3:0] ADDR_MIN  = 4'h3;
  localparam logic [3:0] ADDR_HOUR = 4'h4;
  localparam logic [3:0] ADDR_DOW  = 4'h5;
  localparam logic [3:0] ADDR_DATE = 4'h6;
  localparam logic [3:0] ADDR_MON  = 4'h7;
  localparam logic [3:0] ADDR_YEAR = 4'h8;

  // control bit positions
  localparam int unsigned CB_LOWBAT = 7;
  localparam int unsigned CB_CENT   = 5;
  localparam int unsigned CB_POR    = 4;
  localparam int unsigned CB_WR     = 1;
  localparam int unsigned CB_RD     = 0;

  localparam rtc_time_t TIME_RST = '{year: 8'h00, mon: 5'h01, date: 6'h01,
                                     dow: 3'd1, hour: 6'h00, min: 7'h00,
                                     sec: 7'h00};

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] year);
    logic [7:0] yb;
    yb = 8'(year[7:4] * 4'd10) + {4'h0, year[3:0]};
    case (mon)
      5'h02:                      return (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS = 32768
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   en_i,
  input  logic                                   tick_i,
  input  logic                                   clr_i,
  output logic                                   sec_o,
  output logic [((TICKS > 1) ? $clog2(TICKS) : 1)-1:0] cnt_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign sec_o = en_i & tick_i & (cnt_q == LAST);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t time_o,
  output logic      year_wrap_o
);
  rtc_time_t cur_q, nxt;
  logic      wrap;

  always_comb begin
    nxt  = cur_q;
    wrap = 1'b0;
    if (cur_q.sec >= 7'h59) begin
      nxt.sec = '0;
      if (cur_q.min >= 7'h59) begin
        nxt.min = '0;
        if (cur_q.hour >= 6'h23) begin
          nxt.hour = '0;
          nxt.dow  = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
          if (cur_q.date >= month_last(cur_q.mon, cur_q.year)) begin
            nxt.date = 6'h01;
            if (cur_q.mon >= 5'h12) begin
              nxt.mon = 5'h01;
              if (cur_q.year == 8'h99) begin
                nxt.year = 8'h00;
                wrap     = 1'b1;
              end else begin
                nxt.year = bcd_next(cur_q.year);
              end
            end else begin
              nxt.mon = 5'(bcd_next({3'b0, cur_q.mon}));
            end
          end else begin
            nxt.date = 6'(bcd_next({2'b0, cur_q.date}));
          end
        end else begin
          nxt.hour = 6'(bcd_next({2'b0, cur_q.hour}));
        end
      end else begin
        nxt.min = 7'(bcd_next({1'b0, cur_q.min}));
      end
    end else begin
      nxt.sec = 7'(bcd_next({1'b0, cur_q.sec}));
    end
  end

  // load takes priority over a coincident advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= TIME_RST;
    else if (load_i) cur_q <= load_val_i;
    else if (adv_i)  cur_q <= nxt;
  end

  assign time_o      = cur_q;
  assign year_wrap_o = adv_i & ~load_i & wrap;
endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       batt_low_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  logic [7:0] ctrl_q, cal_q;
  rtc_time_t  live, snap_q, hold_q, view;
  logic       ctrl_wr, cal_wr, time_wr;
  logic       rd_mode, wr_mode, rd_rise, wr_rise, wr_release;
  logic       osc_en, sec_pulse, year_wrap;
  logic [CW-1:0] presc_cnt;

  assign ctrl_wr    = we_i && (addr_i == ADDR_CTRL);
  assign cal_wr     = we_i && (addr_i == ADDR_CAL);
  assign time_wr    = we_i && (addr_i >= ADDR_SEC) && (addr_i <= ADDR_YEAR);
  assign rd_mode    = ctrl_q[CB_RD];
  assign wr_mode    = ctrl_q[CB_WR];
  assign rd_rise    = ctrl_wr & wdata_i[CB_RD] & ~rd_mode;
  assign wr_rise    = ctrl_wr & wdata_i[CB_WR] & ~wr_mode;
  assign wr_release = ctrl_wr & ~wdata_i[CB_WR] & wr_mode;
  assign osc_en     = ~cal_q[7];

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_en),
    .tick_i (tick_i),
    .clr_i  (wr_release),
    .sec_o  (sec_pulse),
    .cnt_o  (presc_cnt)
  );

  rtc_calendar i_cal (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (sec_pulse),
    .load_i      (wr_release),
    .load_val_i  (hold_q),
    .time_o      (live),
    .year_wrap_o (year_wrap)
  );

  // control: flags are cleared by writing 0, set only by hardware
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h10;
      cal_q  <= 8'h80;
    end else begin
      ctrl_q[CB_LOWBAT] <= (ctrl_q[CB_LOWBAT] & (~ctrl_wr | wdata_i[CB_LOWBAT])) | batt_low_i;
      ctrl_q[CB_CENT]   <= (ctrl_q[CB_CENT] & (~ctrl_wr | wdata_i[CB_CENT])) | year_wrap;
      ctrl_q[CB_POR]    <= ctrl_q[CB_POR] & (~ctrl_wr | wdata_i[CB_POR]);
      if (ctrl_wr) begin
        ctrl_q[6]   <= wdata_i[6];
        ctrl_q[3:0] <= wdata_i[3:0];
      end
      if (cal_wr) cal_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= TIME_RST;
    else if (rd_rise) snap_q <= live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= TIME_RST;
    end else if (wr_rise) begin
      hold_q <= live;
    end else if (time_wr && wr_mode) begin
      case (addr_i)
        ADDR_SEC:  hold_q.sec  <= wdata_i[6:0];
        ADDR_MIN:  hold_q.min  <= wdata_i[6:0];
        ADDR_HOUR: hold_q.hour <= wdata_i[5:0];
        ADDR_DOW:  hold_q.dow  <= wdata_i[2:0];
        ADDR_DATE: hold_q.date <= wdata_i[5:0];
        ADDR_MON:  hold_q.mon  <= wdata_i[4:0];
        ADDR_YEAR: hold_q.year <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign view = wr_mode ? hold_q : (rd_mode ? snap_q : live);

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_CAL:  rdata_o = cal_q;
      ADDR_SEC:  rdata_o = {1'b0, view.sec};
      ADDR_MIN:  rdata_o = {1'b0, view.min};
      ADDR_HOUR: rdata_o = {2'b0, view.hour};
      ADDR_DOW:  rdata_o = {5'b0, view.dow};
      ADDR_DATE: rdata_o = {2'b0, view.date};
      ADDR_MON:  rdata_o = {3'b0, view.mon};
      ADDR_YEAR: rdata_o = view.year;
      default:   rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_regfile_chk.sv
module rtc_bcd_regfile_chk
  import rtc_pkg::*;
#(
  parameter int unsigned CW = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          osc_en,
  input logic          wr_release,
  input logic          rd_mode,
  input logic          wr_mode,
  input logic [7:0]    ctrl_q,
  input rtc_time_t     live,
  input rtc_time_t     snap_q,
  input rtc_time_t     hold_q,
  input logic [CW-1:0] presc_cnt
);
  p_osc_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en && !wr_release) |=> $stable(live));

  p_snap_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode && $past(rd_mode)) |-> $stable(snap_q));

  p_hold_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_mode) |-> (live == $past(hold_q) && presc_cnt == '0));

  p_century_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q[CB_CENT]) |-> ($past(live.year) == 8'h99 && live.year == 8'h00));

  p_por_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(ctrl_q[CB_POR]));
endmodule

bind rtc_bcd_regfile rtc_bcd_regfile_chk #(.CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_en     (osc_en),
  .wr_release (wr_release),
  .rd_mode    (rd_mode),
  .wr_mode    (wr_mode),
  .ctrl_q     (ctrl_q),
  .live       (live),
  .snap_q     (snap_q),
  .hold_q     (hold_q),
  .presc_cnt  (presc_cnt)
);

// File: tb/test_rtc_bcd_regfile.sv
module test_rtc_bcd_regfile;
  localparam int unsigned TPS = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       batt_low_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_bcd_regfile #(.TICKS_PER_SEC(TPS)) i_rtc_bcd_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .batt_low_i(batt_low_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o)
  );

  typedef struct packed {
    logic [7:0] mon, date, year, e_date, e_mon, e_year;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{8'h02, 8'h28, 8'h23, 8'h01, 8'h03, 8'h23},
    '{8'h02, 8'h28, 8'h24, 8'h29, 8'h02, 8'h24},
    '{8'h02, 8'h29, 8'h24, 8'h01, 8'h03, 8'h24},
    '{8'h04, 8'h30, 8'h23, 8'h01, 8'h05, 8'h23},
    '{8'h01, 8'h31, 8'h23, 8'h01, 8'h02, 8'h23},
    '{8'h12, 8'h31, 8'h99, 8'h01, 8'h01, 8'h00},
    '{8'h07, 8'h15, 8'h23, 8'h16, 8'h07, 8'h23},
    '{8'h09, 8'h30, 8'h00, 8'h01, 8'h10, 8'h00},
    '{8'h11, 8'h30, 8'h12, 8'h01, 8'h12, 8'h12},
    '{8'h12, 8'h31, 8'h41, 8'h01, 8'h01, 8'h42}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(4'h0, 8'h02);
    wr(4'h2, s); wr(4'h3, mi); wr(4'h4, h); wr(4'h5, dw);
    wr(4'h6, dt); wr(4'h7, mo); wr(4'h8, y);
    wr(4'h0, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); chk("R1", "ctrl", v, 8'h10);
    rd(4'h1, v); chk("R1", "cal", v, 8'h80);
    rd(4'h2, v); chk("R1", "sec", v, 8'h00);
    rd(4'h5, v); chk("R1", "dow", v, 8'h01);
    rd(4'h6, v); chk("R1", "date", v, 8'h01);
    rd(4'h7, v); chk("R1", "mon", v, 8'h01);

    // R2 unmapped addresses
    rd(4'h9, v); chk("R2", "addr9", v, 8'h00);
    rd(4'hF, v); chk("R2", "addrF", v, 8'h00);

    // R3 oscillator gate and prescale
    tick(8);
    rd(4'h2, v); chk("R3", "stopped sec", v, 8'h00);
    wr(4'h1, 8'h00);
    tick(4);
    rd(4'h2, v); chk("R3", "one second", v, 8'h01);
    tick(3);
    rd(4'h2, v); chk("R3", "before terminal", v, 8'h01);
    tick(1);
    rd(4'h2, v); chk("R3", "two seconds", v, 8'h02);

    // R9 time writes outside write mode ignored
    wr(4'h2, 8'h45);
    rd(4'h2, v); chk("R9", "sec unchanged", v, 8'h02);

    // R10 sticky flags
    batt_low_i = 1'b1; @(negedge clk); batt_low_i = 1'b0;
    rd(4'h0, v); chk("R10", "lowbat set", v, 8'h90);
    wr(4'h0, 8'h90);
    rd(4'h0, v); chk("R10", "write 1 keeps", v, 8'h90);
    wr(4'h0, 8'h00);
    rd(4'h0, v); chk("R10", "write 0 clears", v, 8'h00);

    // R11 field widths
    wr(4'h0, 8'h02);
    wr(4'h2, 8'hFF); rd(4'h2, v); chk("R11", "sec mask", v, 8'h7F);
    wr(4'h4, 8'hFF); rd(4'h4, v); chk("R11", "hour mask", v, 8'h3F);
    wr(4'h5, 8'hFF); rd(4'h5, v); chk("R11", "dow mask", v, 8'h07);
    wr(4'h7, 8'hFF); rd(4'h7, v); chk("R11", "mon mask", v, 8'h1F);
    wr(4'h0, 8'h00);

    // R4 R5 R6 rollover table
    for (int k = 0; k < 10; k++) begin
      set_time(8'h59, 8'h59, 8'h23, 8'h07, VECS[k].date, VECS[k].mon, VECS[k].year);
      tick(4);
      rd(4'h2, v); chk("R4", "sec wrap", v, 8'h00);
      rd(4'h3, v); chk("R4", "min wrap", v, 8'h00);
      rd(4'h4, v); chk("R4", "hour wrap", v, 8'h00);
      rd(4'h5, v); chk("R4", "dow wrap", v, 8'h01);
      rd(4'h6, v); chk("R5", "date", v, VECS[k].e_date);
      rd(4'h7, v); chk("R4", "month", v, VECS[k].e_mon);
      rd(4'h8, v); chk("R4", "year", v, VECS[k].e_year);
      rd(4'h0, v); chk("R6", "century flag", {7'b0, v[5]}, {7'b0, (VECS[k].year == 8'h99)});
      wr(4'h0, 8'h00);
      rd(4'h0, v); chk("R6", "century cleared", {7'b0, v[5]}, 8'h00);
    end

    // R7 read snapshot
    set_time(8'h30, 8'h10, 8'h08, 8'h02, 8'h05, 8'h03, 8'h25);
    wr(4'h0, 8'h01);
    tick(4);
    rd(4'h2, v); chk("R7", "frozen sec", v, 8'h30);
    wr(4'h0, 8'h00);
    rd(4'h2, v); chk("R7", "live sec", v, 8'h31);

    // R8 partial update through hold copy
    set_time(8'h10, 8'h20, 8'h05, 8'h03, 8'h15, 8'h06, 8'h23);
    wr(4'h0, 8'h02);
    wr(4'h3, 8'h42);
    tick(4);
    rd(4'h2, v); chk("R8", "hold view sec", v, 8'h10);
    rd(4'h3, v); chk("R8", "hold view min", v, 8'h42);
    wr(4'h0, 8'h00);
    rd(4'h2, v); chk("R8", "loaded sec", v, 8'h10);
    rd(4'h3, v); chk("R8", "loaded min", v, 8'h42);
    rd(4'h4, v); chk("R8", "kept hour", v, 8'h05);
    tick(3);
    rd(4'h2, v); chk("R8", "prescaler cleared", v, 8'h10);
    tick(1);
    rd(4'h2, v); chk("R8", "next second", v, 8'h11);

    // R12 release coincident with second advance
    set_time(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h30);
    tick(3);
    wr(4'h0, 8'h02);
    wr(4'h2, 8'h20);
    addr_i = 4'h0; wdata_i = 8'h00; we_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0; tick_i = 1'b0;
    rd(4'h2, v); chk("R12", "load wins", v, 8'h20);
    tick(3);
    rd(4'h2, v); chk("R12", "full period", v, 8'h20);
    tick(1);
    rd(4'h2, v); chk("R12", "advance", v, 8'h21);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule